// File: doc/BRIEF.md
# Interleaved I/Q Converter Input Demultiplexer

This block is the digital front end of a two-channel converter. A single data bus runs at twice the per-channel update rate. Every word on the bus carries a select bit that marks it as an I word or a Q word. An invert bit can also scramble the word with XOR, and the block undoes that scrambling. Each word is then changed from signed or offset form into an unsigned code. The block pairs each I word with the Q word that follows it. Both codes of a pair are presented together on one clock edge, and a one-cycle strobe marks that edge.

The I path has one more cycle of latency than the Q path. The I word arrives one clock before its Q partner, so the two codes leave on the same edge. A sticky flag records any break in the expected I-then-Q order. A power-down input holds both outputs at midscale and empties the pipeline. After power-down is released, a programmable wake-up count must run out before new words are accepted.

Top module: `iq_dac_demux`

## Requirements
- R1: A word is captured on each rising clock edge. If its select input is 1 it is an I word, and if it is 0 it is a Q word. An I word followed directly by a Q word forms one output pair.
- R2: If a word's invert input is 1, every data bit is inverted before conversion. If it is 0, the data passes through unchanged.
- R3: The format input is captured with each word. With format 1 the word is two's complement and its MSB is inverted, so 0x2000 becomes 0x0000, 0x1FFF becomes 0x3FFF and 0x0000 becomes 0x2000. With format 0 the word is offset binary and is passed through as it is.
- R4: The I code appears on the outputs 9 clock edges after the I word is captured. The Q code appears 8 edges after the Q word is captured. Both outputs change on the same edge. `updStrobe` is 1 for exactly the one cycle that follows that edge.
- R5: Between strobes, `codeI` and `codeQ` keep their last values.
- R6: Two I words in a row: the later one replaces the pending I word. A Q word with no pending I word is discarded. Either case sets `seqErr` one edge after the word that caused it is captured. `seqErr` then stays 1 until reset.
- R7: While `powerDown` is 1, each edge sets both codes to midscale (0x2000) and sets the strobe to 0. It also clears the pending word and every pair in flight. Words are not accepted.
- R8: `ready` is 0 while `powerDown` is 1. It stays 0 for WAKE_CYCLES edges after the last edge on which `powerDown` was 1. The first word accepted is the one captured on the first edge that follows a cycle in which `ready` was 1.
- R9: The reset is synchronous and active low. It sets both codes to midscale, the strobe to 0, `seqErr` to 0 and `ready` to 1, and clears the pending word and all pairs in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock, twice the per-channel update rate |
| rstN | input | 1 | Synchronous active-low reset |
| dataIn | input | DATA_W | Interleaved data word |
| selI | input | 1 | 1 = I word, 0 = Q word |
| invIn | input | 1 | 1 = word arrives bit-inverted |
| twosComp | input | 1 | 1 = two's complement, 0 = offset binary |
| powerDown | input | 1 | Active-high idle request |
| codeI | output | DATA_W | Unsigned I channel code |
| codeQ | output | DATA_W | Unsigned Q channel code |
| updStrobe | output | 1 | One-cycle pulse after each paired update |
| seqErr | output | 1 | Sticky I/Q ordering error |
| ready | output | 1 | Words are being accepted |

## Verification
The assertions assume that every input carries a known value at each edge. They also assume that WAKE_CYCLES is at least one, so that a falling `powerDown` is always followed by a cycle in which `ready` is low.

Strobe spacing is asserted without any condition on the order of select values. Because of this, the stimulus may freely break the I-then-Q order. The random part of the stimulus sends well-ordered pairs. Directed segments add doubled I words, orphan Q words, and a power-down with its wake-up window, so that these cases are covered.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;

  // Control strobes from the control unit to the datapath.
  typedef struct packed {
    logic flush;     // asleep: drive every pipeline stage to midscale
    logic loadPend;  // the captured word is an I word: hold it
    logic emitPair;  // the captured word is a Q word with a pending I word
    logic loadOut;   // the last alignment stage holds a valid pair
  } demux_ctl_t;

  // Q latency from capture to output; I latency is one more.
  localparam int LAT_Q = 8;
  localparam int LAT_I = LAT_Q + 1;
  // Stages between the pair register and the output register.
  localparam int ALIGN_DEPTH = LAT_Q - 2;

endpackage

// File: rtl/iq_demux_ctrl.sv
module iq_demux_ctrl
  import iq_demux_pkg::*;
#(
  parameter int WAKE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selI,
  input  logic       powerDown,
  output demux_ctl_t ctl,
  output logic       updStrobe,
  output logic       seqErr,
  output logic       ready
);

  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [WAKE_W-1:0]      wakeCnt;
  logic                   asleep;
  logic                   wordValid;
  logic                   wordSel;
  logic                   havePend;
  logic [ALIGN_DEPTH:0]   chain;
  logic                   emit;

  assign asleep = powerDown || (wakeCnt != '0);
  assign ready  = !asleep;
  assign emit   = wordValid && !wordSel && havePend;

  always_comb begin
    ctl.flush    = asleep;
    ctl.loadPend = !asleep && wordValid && wordSel;
    ctl.emitPair = !asleep && emit;
    ctl.loadOut  = !asleep && chain[ALIGN_DEPTH];
  end

  // Wake-up counter: reloaded while powered down, counts down after release.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (powerDown) begin
      wakeCnt <= WAKE_W'(WAKE_CYCLES);
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  // Capture-stage qualifiers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordSel   <= 1'b0;
    end else begin
      wordValid <= !asleep;
      wordSel   <= selI;
    end
  end

  // Pairing state, valid chain, strobe and sticky ordering error.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePend  <= 1'b0;
      chain     <= '0;
      updStrobe <= 1'b0;
      seqErr    <= 1'b0;
    end else if (asleep) begin
      havePend  <= 1'b0;
      chain     <= '0;
      updStrobe <= 1'b0;
    end else begin
      if (wordValid) begin
        if (wordSel) begin
          if (havePend) seqErr <= 1'b1;
          havePend <= 1'b1;
        end else if (havePend) begin
          havePend <= 1'b0;
        end else begin
          seqErr <= 1'b1;
        end
      end
      chain     <= {chain[ALIGN_DEPTH-1:0], emit};
      updStrobe <= chain[ALIGN_DEPTH];
    end
  end

endmodule

// File: rtl/iq_demux_path.sv
module iq_demux_path
  import iq_demux_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              invIn,
  input  logic              twosComp,
  input  demux_ctl_t        ctl,
  output logic [DATA_W-1:0] codeI,
  output logic [DATA_W-1:0] codeQ
);

  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] wData;
  logic              wInv;
  logic              wFmt;
  logic [DATA_W-1:0] decoded;
  logic [DATA_W-1:0] pendI;
  logic [DATA_W-1:0] pairI;
  logic [DATA_W-1:0] pairQ;
  logic [DATA_W-1:0] dlyI [ALIGN_DEPTH];
  logic [DATA_W-1:0] dlyQ [ALIGN_DEPTH];

  // Capture register: word, invert flag and format flag travel together.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wData <= MID;
      wInv  <= 1'b0;
      wFmt  <= 1'b0;
    end else begin
      wData <= dataIn;
      wInv  <= invIn;
      wFmt  <= twosComp;
    end
  end

  // Undo the scrambling, then flip the sign bit for two's complement words.
  assign decoded = wData ^ {DATA_W{wInv}} ^ {wFmt, {(DATA_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      pendI <= MID;
    end else if (ctl.loadPend) begin
      pendI <= decoded;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      pairI <= MID;
      pairQ <= MID;
    end else if (ctl.emitPair) begin
      pairI <= pendI;
      pairQ <= decoded;
    end
  end

  // Alignment stages between the pair register and the outputs.
  for (genvar g = 0; g < ALIGN_DEPTH; g++) begin : g_align
    always_ff @(posedge clk) begin
      if (!rstN || ctl.flush) begin
        dlyI[g] <= MID;
        dlyQ[g] <= MID;
      end else if (g == 0) begin
        dlyI[g] <= pairI;
        dlyQ[g] <= pairQ;
      end else begin
        dlyI[g] <= dlyI[(g == 0) ? 0 : g-1];
        dlyQ[g] <= dlyQ[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      codeI <= MID;
      codeQ <= MID;
    end else if (ctl.loadOut) begin
      codeI <= dlyI[ALIGN_DEPTH-1];
      codeQ <= dlyQ[ALIGN_DEPTH-1];
    end
  end

endmodule

// File: rtl/iq_dac_demux.sv
module iq_dac_demux
  import iq_demux_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int WAKE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              selI,
  input  logic              invIn,
  input  logic              twosComp,
  input  logic              powerDown,
  output logic [DATA_W-1:0] codeI,
  output logic [DATA_W-1:0] codeQ,
  output logic              updStrobe,
  output logic              seqErr,
  output logic              ready
);

  demux_ctl_t ctl;

  iq_demux_ctrl #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .selI      (selI),
    .powerDown (powerDown),
    .ctl       (ctl),
    .updStrobe (updStrobe),
    .seqErr    (seqErr),
    .ready     (ready)
  );

  iq_demux_path #(
    .DATA_W(DATA_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .invIn    (invIn),
    .twosComp (twosComp),
    .ctl      (ctl),
    .codeI    (codeI),
    .codeQ    (codeQ)
  );

endmodule

// File: rtl/iq_dac_demux_chk.sv
module iq_dac_demux_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerDown,
  input logic [DATA_W-1:0] codeI,
  input logic [DATA_W-1:0] codeQ,
  input logic              updStrobe,
  input logic              seqErr,
  input logic              ready
);

  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  // R4: a paired update never repeats on the next edge
  a_r4_strobe_gap: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe);

  // R7: power-down forces idle outputs on the following edge
  a_r7_pd_idle: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (codeI == MID && codeQ == MID && !updStrobe));

  // R6: the ordering flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr);

  // R8: no update leaves while not ready
  a_r8_asleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> !updStrobe);

  // R8: release of power-down starts a wake-up window
  a_r8_wake_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerDown) |-> !ready);

  // R9: reset state
  a_r9_reset_idle: assert property (@(posedge clk)
    !rstN |=> (codeI == MID && codeQ == MID && !updStrobe && !seqErr));

endmodule

bind iq_dac_demux iq_dac_demux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .powerDown (powerDown),
  .codeI     (codeI),
  .codeQ     (codeQ),
  .updStrobe (updStrobe),
  .seqErr    (seqErr),
  .ready     (ready)
);

// File: tb/iq_dac_demux_tb.sv
module iq_dac_demux_tb;

  localparam int DATA_W     = 14;
  localparam int WAKE       = 64;
  localparam int CLK_PERIOD = 10;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              selI = 1'b0;
  logic              invIn = 1'b0;
  logic              twosComp = 1'b0;
  logic              powerDown = 1'b0;
  logic [DATA_W-1:0] codeI;
  logic [DATA_W-1:0] codeQ;
  logic              updStrobe;
  logic              seqErr;
  logic              ready;

  iq_dac_demux #(.DATA_W(DATA_W), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .selI(selI), .invIn(invIn),
    .twosComp(twosComp), .powerDown(powerDown), .codeI(codeI), .codeQ(codeQ),
    .updStrobe(updStrobe), .seqErr(seqErr), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  // Reference model state, built from the requirements.
  logic [DATA_W-1:0] holdI, holdQ, pendI;
  logic              pendValid, errPend, expErr, expStb;
  logic [DATA_W-1:0] schedI [16];
  logic [DATA_W-1:0] schedQ [16];
  logic              schedV [16];
  int                wakeLeft;
  int                edgeNo;

  function automatic logic [DATA_W-1:0] fDec(logic [DATA_W-1:0] d, logic inv, logic tc);
    logic [DATA_W-1:0] r;
    r = inv ? ~d : d;
    if (tc) r[DATA_W-1] = ~r[DATA_W-1];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", req, what, act, exp, edgeNo);
    end
  endtask

  task automatic modelClear();
    for (int k = 0; k < 16; k++) schedV[k] = 1'b0;
    pendValid = 1'b0;
    errPend   = 1'b0;
    holdI     = MID;
    holdQ     = MID;
    expStb    = 1'b0;
  endtask

  // One clock: drive a word, advance the model by one edge, check outputs.
  task automatic cyc(logic [DATA_W-1:0] d, logic s, logic inv, logic tc, logic pd);
    logic accepted;
    int   slot;
    dataIn = d; selI = s; invIn = inv; twosComp = tc; powerDown = pd;
    accepted = !pd && (wakeLeft == 0);
    if (!accepted) begin
      modelClear();
    end else begin
      if (errPend) expErr = 1'b1;
      errPend = 1'b0;
      slot = edgeNo % 16;
      if (schedV[slot]) begin
        holdI = schedI[slot]; holdQ = schedQ[slot]; expStb = 1'b1; schedV[slot] = 1'b0;
      end else begin
        expStb = 1'b0;
      end
      if (s) begin
        if (pendValid) errPend = 1'b1;
        pendI = fDec(d, inv, tc);
        pendValid = 1'b1;
      end else if (pendValid) begin
        slot = (edgeNo + 8) % 16;
        schedI[slot] = pendI;
        schedQ[slot] = fDec(d, inv, tc);
        schedV[slot] = 1'b1;
        pendValid = 1'b0;
      end else begin
        errPend = 1'b1;
      end
    end
    if (pd) wakeLeft = WAKE;
    else if (wakeLeft > 0) wakeLeft--;
    @(negedge clk);
    chk(tag, "codeI", 32'(codeI), 32'(holdI));
    chk(tag, "codeQ", 32'(codeQ), 32'(holdQ));
    chk(tag, "updStrobe", 32'(updStrobe), 32'(expStb));
    chk("R6", "seqErr", 32'(seqErr), 32'(expErr));
    chk("R8", "ready", 32'(ready), 32'((wakeLeft == 0) && !pd));
    edgeNo++;
  endtask

  task automatic pair(logic [DATA_W-1:0] di, logic [DATA_W-1:0] dq,
                      logic invI, logic invQ, logic tc);
    cyc(di, 1'b1, invI, tc, 1'b0);
    cyc(dq, 1'b0, invQ, tc, 1'b0);
  endtask

  task automatic flushPipe(int n);
    for (int k = 0; k < n; k++) pair(MID, MID, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    expErr = 1'b0; wakeLeft = 0; edgeNo = 0; pendI = MID;

    // R9: synchronous reset state
    repeat (3) @(negedge clk);
    chk("R9", "codeI after reset", 32'(codeI), 32'(MID));
    chk("R9", "codeQ after reset", 32'(codeQ), 32'(MID));
    chk("R9", "strobe after reset", 32'(updStrobe), 32'd0);
    chk("R9", "seqErr after reset", 32'(seqErr), 32'd0);
    chk("R9", "ready after reset", 32'(ready), 32'd1);
    rstN = 1'b1;

    // R3: format corners
    tag = "R3";
    pair(14'h2000, 14'h1FFF, 1'b0, 1'b0, 1'b1);
    pair(14'h0000, 14'h3FFF, 1'b0, 1'b0, 1'b0);
    pair(14'h0000, 14'h0001, 1'b0, 1'b0, 1'b1);
    flushPipe(5);
    chk("R3", "tc 0x0000 to midscale on I", 32'(codeI), 32'h2000);

    // R2: inverted words
    tag = "R2";
    pair(14'h0F0F, 14'h3333, 1'b1, 1'b0, 1'b0);
    pair(14'h0000, 14'h3FFF, 1'b1, 1'b1, 1'b0);
    pair(14'h1234, 14'h2ABC, 1'b0, 1'b1, 1'b1);
    flushPipe(5);

    // R1 and R4: random well-ordered pairs
    tag = "R1";
    for (int k = 0; k < 150; k++)
      pair(DATA_W'($urandom), DATA_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    tag = "R4";
    for (int k = 0; k < 150; k++)
      pair(DATA_W'($urandom), DATA_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    flushPipe(5);

    // R6: doubled I word, then an orphan Q word
    tag = "R6";
    cyc(14'h0111, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(14'h0222, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(14'h0333, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(14'h0444, 1'b0, 1'b0, 1'b0, 1'b0);
    flushPipe(6);

    // R5: one pair followed by orphan Q words; outputs hold
    tag = "R5";
    pair(14'h3A5A, 14'h05A5, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) cyc(DATA_W'($urandom), 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "codeI held", 32'(codeI), 32'h3A5A);

    // R7: power-down in the middle of traffic
    tag = "R7";
    for (int k = 0; k < 3; k++)
      pair(DATA_W'($urandom), DATA_W'($urandom), 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) cyc(DATA_W'($urandom), 1'(k), 1'b0, 1'b1, 1'b1);
    chk("R7", "codeQ idle", 32'(codeQ), 32'(MID));

    // R8: wake-up window, then traffic across its end
    tag = "R8";
    for (int k = 0; k < WAKE/2 + 10; k++)
      pair(DATA_W'($urandom), DATA_W'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    tag = "R4";
    for (int k = 0; k < 40; k++)
      pair(DATA_W'($urandom), DATA_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    flushPipe(5);

    summary();
    $finish;
  end

endmodule